// File: doc/BRIEF.md
# Presence Filter and Interrupt Aggregator

This block watches two asynchronous presence inputs from a display link: the hot-plug detect line and the receiver-sense line. Each input is brought into the clock domain through a two-flop synchroniser. It then passes through two filter stages. The first stage rejects short glitches. The second stage requires the new level to persist for a coarse minimum time, counted in units of 1024 clocks. Each channel has its own pair of thresholds.

When a filtered level changes, the block raises a rise or fall event for that channel. These events, together with event pulses from neighbouring logic, feed a small interrupt block. The interrupt block holds a sticky status register, a per-source enable mask, a register through which software can set status bits, and a write-one-to-clear register. The single interrupt output is asserted while any status bit is set and also enabled by its mask bit.

Software reaches all of this through a simple register port. A write takes effect on the clock edge on which the write enable is sampled. A read is combinational from the read address.

Top module: `presence_filter_irq`

## Requirements
- R1: In the glitch stage, with glitch threshold N, a change on a raw input that lasts N clocks or fewer never alters the filtered level and raises no event. A change that lasts N+1 clocks passes this stage.
- R2: With valid-width threshold M, a level leaving the glitch stage must persist for M*1024+1 clocks, which is longer than M*1024, before the filtered level follows it. A level that lasts exactly M*1024 clocks is discarded.
- R3: A raw input change that persists reaches the filtered level, and its event bit, exactly 4+N+1024*M clock edges after the first edge that samples it. This count includes the two synchroniser flops.
- R4: The two channels have independent thresholds. The filtered hot-plug level reads at bit 0 of the levels register, and the filtered receiver-sense level at bit 1.
- R5: A filtered rising edge sets status bit 1 for hot-plug and bit 6 for receiver-sense. A filtered falling edge sets bit 2 and bit 7 respectively. The bit is set on the same edge on which the level changes.
- R6: Each bit of the external event input sets the status bit at the same position. Bit 0 is the core interrupt, bit 5 is the I2C timeout, and bits 3 and 4 carry content-protection events.
- R7: The interrupt output is high exactly while some status bit and its mask bit are both 1. The mask is active high.
- R8: Writing the status register sets every status bit written with 1. Bits written with 0 are left unchanged. A status bit stays set until it is cleared.
- R9: Writing the clear register drops every status bit written with 1 and leaves the others unchanged.
- R10: When a set from any source and a clear hit the same status bit in the same cycle, the bit ends up set.
- R11: While rst_n is low at a clock edge, status, mask, both threshold registers and both filtered levels return to 0, and the interrupt output goes low.
- R12: The register map is as follows. Address 0 holds the hot-plug thresholds: N in bits [3:0] and M in bits [15:4]. Address 1 holds the receiver-sense thresholds in the same layout. Address 2 is the mask, address 3 is status, and address 4 is clear, which always reads 0. Address 5 holds the levels. Threshold and mask registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write address |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_addr | input | 3 | Register read address |
| reg_rd_data | output | 16 | Combinational read data |
| hpd_raw | input | 1 | Asynchronous hot-plug detect input |
| rxsense_raw | input | 1 | Asynchronous receiver-sense input |
| ext_evt | input | 8 | Single-cycle event pulses from neighbouring logic |
| irq | output | 1 | Aggregated interrupt request |

## Verification
The checker tests the following on every cycle:
- Status bits stay set until they are cleared.
- A clear empties exactly the bits it names, unless a set hits the same bit in that cycle, in which case the set wins.
- Every filtered level change comes with its rise or fall status bit.
- Reset empties status and mask and lowers the interrupt.

Only the bench scenarios can show the timing thresholds. These are the exact pulse widths at which the glitch and valid-width stages accept or reject a change, the fixed end-to-end latency, and the fact that the two channels use separate settings.

// File: rtl/pfi_pkg.sv
// Shared constants for the presence filter and interrupt aggregator.
// Assumes an 8-source interrupt vector and a 3-bit register address.
package pfi_pkg;
    localparam int GLITCH_W   = 4;    // glitch threshold width
    localparam int VALID_W    = 12;   // valid-width threshold width
    localparam int UNIT_LOG2  = 10;   // valid-width unit is 2**UNIT_LOG2 clocks
    localparam int NUM_SRC    = 8;    // interrupt sources
    localparam int NUM_CH     = 2;    // filtered channels
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 16;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_HPD_CFG = 3'd0;
    localparam logic [ADDR_W-1:0] A_RXS_CFG = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK    = 3'd2;
    localparam logic [ADDR_W-1:0] A_STATUS  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CLEAR   = 3'd4;
    localparam logic [ADDR_W-1:0] A_LEVELS  = 3'd5;

    // Status bit position of a channel's rising-edge event
    function automatic int rise_pos(input int ch);
        return (ch == 0) ? 1 : 6;
    endfunction

    // Status bit position of a channel's falling-edge event
    function automatic int fall_pos(input int ch);
        return (ch == 0) ? 2 : 7;
    endfunction
endpackage

// File: rtl/pfi_sync2.sv
// Two-flop synchroniser for asynchronous level inputs.
// Assumes the inputs are slow levels; no pulse capture is attempted.
module pfi_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Shift the input through two flops into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;
endmodule

// File: rtl/pfi_level_filter.sv
// One presence channel: synchroniser, glitch stage, coarse valid-width stage,
// and edge events. The glitch stage accepts a change after it has lasted
// glitch_max+1 clocks. The valid stage accepts it after
// valid_units*2**UL + 1 clocks. Events are single-cycle pulses on the edge
// where the filtered level changes. Assumes the thresholds are quasi-static;
// a lowered threshold takes effect at once through the >= compare.
module pfi_level_filter #(
    parameter int GW = 4,
    parameter int VW = 12,
    parameter int UL = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw_async,
    input  logic [GW-1:0] glitch_max,
    input  logic [VW-1:0] valid_units,
    output logic          level,
    output logic          rise_evt,
    output logic          fall_evt
);
    localparam int CW = VW + UL;

    logic          smp;
    logic [GW-1:0] gcnt_q;
    logic          glv_q;
    logic [CW-1:0] vcnt_q;
    logic          flv_q;
    logic [CW-1:0] vlimit;
    logic          g_take;
    logic          v_take;

    pfi_sync2 #(.W(1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_async),
        .sync_out (smp)
    );

    // Compute the acceptance conditions of both stages
    always_comb begin
        vlimit = {valid_units, {UL{1'b0}}};
        g_take = (smp != glv_q) && (gcnt_q >= glitch_max);
        v_take = (glv_q != flv_q) && (vcnt_q >= vlimit);
    end

    // Glitch stage: count consecutive differing samples, adopt after N+1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcnt_q <= '0;
            glv_q  <= 1'b0;
        end else if (smp == glv_q) begin
            gcnt_q <= '0;
        end else if (g_take) begin
            glv_q  <= smp;
            gcnt_q <= '0;
        end else begin
            gcnt_q <= gcnt_q + 1'b1;
        end
    end

    // Valid stage: count how long the glitch-free level differs, adopt after M*1024+1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcnt_q <= '0;
            flv_q  <= 1'b0;
        end else if (glv_q == flv_q) begin
            vcnt_q <= '0;
        end else if (v_take) begin
            flv_q  <= glv_q;
            vcnt_q <= '0;
        end else begin
            vcnt_q <= vcnt_q + 1'b1;
        end
    end

    assign level    = flv_q;
    assign rise_evt = v_take & glv_q;
    assign fall_evt = v_take & ~glv_q;
endmodule

// File: rtl/pfi_irq_ctrl.sv
// Sticky interrupt status with hardware and software set, write-one-to-clear,
// and a masked OR to a single request. A set wins over a clear on the same
// bit in the same cycle.
module pfi_irq_ctrl #(
    parameter int NS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] hw_set,
    input  logic [NS-1:0] sw_set,
    input  logic [NS-1:0] sw_clr,
    input  logic [NS-1:0] mask,
    output logic [NS-1:0] status,
    output logic          irq
);
    logic [NS-1:0] status_q;
    logic [NS-1:0] any_set;

    // Merge all set sources
    always_comb begin
        any_set = hw_set | sw_set;
    end

    // Update sticky status: clear first, then set so that set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~sw_clr) | any_set;
        end
    end

    assign status = status_q;
    assign irq    = |(status_q & mask);
endmodule

// File: rtl/presence_filter_irq.sv
// Top: register port, two filtered presence channels, interrupt aggregation.
// Assumes a single clock and synchronous active-low reset. Reads are
// combinational; writes land on the sampling edge.
module presence_filter_irq
    import pfi_pkg::*;
#(
    parameter int GW = pfi_pkg::GLITCH_W,
    parameter int VW = pfi_pkg::VALID_W,
    parameter int UL = pfi_pkg::UNIT_LOG2,
    parameter int NS = pfi_pkg::NUM_SRC,
    parameter int AW = pfi_pkg::ADDR_W,
    parameter int DW = pfi_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [AW-1:0] reg_wr_addr,
    input  logic [DW-1:0] reg_wr_data,
    input  logic [AW-1:0] reg_rd_addr,
    output logic [DW-1:0] reg_rd_data,
    input  logic          hpd_raw,
    input  logic          rxsense_raw,
    input  logic [NS-1:0] ext_evt,
    output logic          irq
);
    localparam int CFG_W = GW + VW;
    localparam int NCH   = pfi_pkg::NUM_CH;

    logic [CFG_W-1:0] cfg_q [NCH];
    logic [NS-1:0]    mask_q;
    logic [NS-1:0]    set_sw;
    logic [NS-1:0]    clr_vec;
    logic [NS-1:0]    set_vec;
    logic [NS-1:0]    status_w;
    logic [NCH-1:0]   raw_in;
    logic [NCH-1:0]   level_w;
    logic [NCH-1:0]   rise_w;
    logic [NCH-1:0]   fall_w;
    logic [NS-1:0]    hw_set;

    assign raw_in = {rxsense_raw, hpd_raw};

    // Per-channel filter instances and their threshold registers
    for (genvar c = 0; c < NCH; c++) begin : gen_ch
        localparam logic [AW-1:0] CFG_ADDR = AW'(c);

        // Hold this channel's thresholds
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[c] <= '0;
            end else if (reg_wr_en && reg_wr_addr == CFG_ADDR) begin
                cfg_q[c] <= reg_wr_data[CFG_W-1:0];
            end
        end

        pfi_level_filter #(.GW(GW), .VW(VW), .UL(UL)) u_filt (
            .clk         (clk),
            .rst_n       (rst_n),
            .raw_async   (raw_in[c]),
            .glitch_max  (cfg_q[c][GW-1:0]),
            .valid_units (cfg_q[c][CFG_W-1:GW]),
            .level       (level_w[c]),
            .rise_evt    (rise_w[c]),
            .fall_evt    (fall_w[c])
        );
    end

    // Hold the interrupt enable mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (reg_wr_en && reg_wr_addr == A_MASK) begin
            mask_q <= reg_wr_data[NS-1:0];
        end
    end

    // Decode software set and clear strobes
    always_comb begin
        set_sw  = '0;
        clr_vec = '0;
        if (reg_wr_en && reg_wr_addr == A_STATUS) set_sw  = reg_wr_data[NS-1:0];
        if (reg_wr_en && reg_wr_addr == A_CLEAR)  clr_vec = reg_wr_data[NS-1:0];
    end

    // Place channel edge events onto their status positions beside external events
    always_comb begin
        hw_set = ext_evt;
        for (int c = 0; c < NCH; c++) begin
            hw_set[rise_pos(c)] = hw_set[rise_pos(c)] | rise_w[c];
            hw_set[fall_pos(c)] = hw_set[fall_pos(c)] | fall_w[c];
        end
        set_vec = hw_set | set_sw;
    end

    pfi_irq_ctrl #(.NS(NS)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (hw_set),
        .sw_set (set_sw),
        .sw_clr (clr_vec),
        .mask   (mask_q),
        .status (status_w),
        .irq    (irq)
    );

    // Select read data by address
    always_comb begin
        reg_rd_data = '0;
        case (reg_rd_addr)
            A_HPD_CFG: reg_rd_data[CFG_W-1:0] = cfg_q[0];
            A_RXS_CFG: reg_rd_data[CFG_W-1:0] = cfg_q[1];
            A_MASK:    reg_rd_data[NS-1:0]    = mask_q;
            A_STATUS:  reg_rd_data[NS-1:0]    = status_w;
            A_LEVELS:  reg_rd_data[NCH-1:0]   = level_w;
            default:   reg_rd_data            = '0;
        endcase
    end
endmodule

// File: rtl/pfi_checker.sv
// Cycle-level properties of the interrupt state and filter events.
// Bound into presence_filter_irq; only observes.
module pfi_checker #(
    parameter int NS = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic [NS-1:0] status,
    input logic [NS-1:0] mask,
    input logic [NS-1:0] set_vec,
    input logic [NS-1:0] clr_vec,
    input logic [1:0]    level
);
    assert_reset_state_R11: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && mask == '0 && !irq));

    assert_sticky_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(status) & ~$past(clr_vec)) & ~status) == '0));

    assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((status & $past(clr_vec) & ~$past(set_vec)) == '0));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec & clr_vec) != '0) |=>
            ((status & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

    assert_hpd_rise_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level[0]) |-> status[1]);

    assert_hpd_fall_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level[0]) |-> status[2]);

    assert_rxs_rise_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level[1]) |-> status[6]);

    assert_rxs_fall_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level[1]) |-> status[7]);
endmodule

bind presence_filter_irq pfi_checker #(.NS(NS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .status  (status_w),
    .mask    (mask_q),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .level   (level_w)
);

// File: tb/tb_presence_filter_irq.sv
`timescale 1ns/1ps
module tb_presence_filter_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_addr = '0;
    logic [15:0] reg_wr_data = '0;
    logic [2:0]  reg_rd_addr = '0;
    logic [15:0] reg_rd_data;
    logic        hpd_raw = 1'b0;
    logic        rxsense_raw = 1'b0;
    logic [7:0]  ext_evt = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    presence_filter_irq dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_addr (reg_rd_addr),
        .reg_rd_data (reg_rd_data),
        .hpd_raw     (hpd_raw),
        .rxsense_raw (rxsense_raw),
        .ext_evt     (ext_evt),
        .irq         (irq)
    );

    // Row: {is_write, addr[2:0], data[15:0], expected[15:0], expected_irq}
    localparam int NV = 18;
    localparam logic [36:0] VECS [0:NV-1] = '{
        {1'b0, 3'd3, 16'h0000, 16'h0000, 1'b0},  // R11 status after reset
        {1'b0, 3'd2, 16'h0000, 16'h0000, 1'b0},  // R11 mask after reset
        {1'b0, 3'd5, 16'h0000, 16'h0000, 1'b0},  // R11 levels after reset
        {1'b1, 3'd3, 16'h0021, 16'h0000, 1'b0},  // R8 set bits 0 and 5
        {1'b0, 3'd3, 16'h0000, 16'h0021, 1'b0},  // R8 read back, R7 mask 0
        {1'b1, 3'd2, 16'h0001, 16'h0000, 1'b0},
        {1'b0, 3'd2, 16'h0000, 16'h0001, 1'b1},  // R7 enabled source
        {1'b1, 3'd3, 16'h0000, 16'h0000, 1'b0},  // R8 zeros do nothing
        {1'b0, 3'd3, 16'h0000, 16'h0021, 1'b1},
        {1'b1, 3'd4, 16'h0001, 16'h0000, 1'b0},  // R9 clear bit 0
        {1'b0, 3'd3, 16'h0000, 16'h0020, 1'b0},
        {1'b1, 3'd2, 16'h0020, 16'h0000, 1'b0},
        {1'b0, 3'd3, 16'h0000, 16'h0020, 1'b1},  // R7 other bit
        {1'b1, 3'd4, 16'h0020, 16'h0000, 1'b0},
        {1'b0, 3'd3, 16'h0000, 16'h0000, 1'b0},
        {1'b0, 3'd4, 16'h0000, 16'h0000, 1'b0},  // R12 clear reads 0
        {1'b1, 3'd0, 16'hABC7, 16'h0000, 1'b0},
        {1'b0, 3'd0, 16'h0000, 16'hABC7, 1'b0}   // R12 threshold readback
    };

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        reg_rd_addr = a;
        #0.1;
        d = reg_rd_data;
    endtask

    // Drive a channel to val for width clocks, then restore the opposite level
    task automatic pulse(input int ch, input logic val, input int width);
        @(negedge clk);
        if (ch == 0) hpd_raw = val; else rxsense_raw = val;
        repeat (width) @(negedge clk);
        if (ch == 0) hpd_raw = ~val; else rxsense_raw = ~val;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Register behaviour table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i][36]) begin
                reg_write(VECS[i][35:33], VECS[i][32:17]);
            end else begin
                reg_read(VECS[i][35:33], rd);
                check($sformatf("R7/R8/R9/R11/R12 table row %0d data", i), rd, VECS[i][16:1]);
                check($sformatf("R7 table row %0d irq", i), {15'd0, irq}, {15'd0, VECS[i][0]});
            end
        end
        reg_write(3'd2, 16'h0000);

        // R3: latency with N=2, M=0 is 6 edges
        reg_write(3'd0, 16'h0002);
        @(negedge clk); hpd_raw = 1'b1;
        repeat (5) @(negedge clk);
        reg_read(3'd5, rd); check("R3 level before latency", rd, 16'h0000);
        @(negedge clk);
        reg_read(3'd5, rd); check("R3 level at latency", rd, 16'h0001);
        reg_read(3'd3, rd); check("R5 hpd rise bit1 same edge", rd, 16'h0002);
        reg_write(3'd4, 16'h00FF);

        // R1: glitch threshold N=3
        reg_write(3'd0, 16'h0003);
        pulse(0, 1'b0, 3); repeat (20) @(negedge clk);
        reg_read(3'd5, rd); check("R1 low glitch of N rejected", rd, 16'h0001);
        reg_read(3'd3, rd); check("R1 no event from glitch", rd, 16'h0000);
        pulse(0, 1'b0, 4); repeat (20) @(negedge clk);
        reg_read(3'd5, rd); check("R1 hpd stays high after N+1 low pulse ends", rd, 16'h0001);
        reg_read(3'd3, rd); check("R5 hpd fall then rise bits", rd, 16'h0006);
        reg_write(3'd4, 16'h00FF);
        @(negedge clk); hpd_raw = 1'b0; repeat (20) @(negedge clk);
        reg_write(3'd4, 16'h00FF);
        pulse(0, 1'b1, 3); repeat (20) @(negedge clk);
        reg_read(3'd5, rd); check("R1 high glitch of N rejected", rd, 16'h0000);
        reg_read(3'd3, rd); check("R1 no event from high glitch", rd, 16'h0000);
        pulse(0, 1'b1, 4); repeat (20) @(negedge clk);
        reg_read(3'd3, rd); check("R1 high N+1 pulse gives rise and fall", rd, 16'h0006);
        reg_write(3'd4, 16'h00FF);

        // R2: receiver-sense valid width M=1, N=0
        reg_write(3'd1, 16'h0010);
        pulse(1, 1'b1, 1024); repeat (1100) @(negedge clk);
        reg_read(3'd5, rd); check("R2 pulse of M*1024 rejected", rd, 16'h0000);
        reg_read(3'd3, rd); check("R2 no event from short level", rd, 16'h0000);
        pulse(1, 1'b1, 1025); repeat (10) @(negedge clk);
        reg_read(3'd5, rd); check("R2/R4 pulse of M*1024+1 accepted at bit1", rd, 16'h0002);
        reg_read(3'd3, rd); check("R5 rxsense rise bit6", rd, 16'h0040);
        repeat (1100) @(negedge clk);
        reg_read(3'd5, rd); check("R2 rxsense returns low", rd, 16'h0000);
        reg_read(3'd3, rd); check("R5 rxsense fall bit7", rd, 16'h00C0);
        reg_write(3'd4, 16'h00FF);

        // R4: independent settings, rxsense N=0 M=0 while hpd N=3
        reg_write(3'd1, 16'h0000);
        pulse(1, 1'b1, 1); pulse(0, 1'b1, 1); repeat (20) @(negedge clk);
        reg_read(3'd3, rd); check("R4 short pulse passes rxsense only", rd, 16'h00C0);
        reg_write(3'd4, 16'h00FF);

        // R6: external events at their positions
        @(negedge clk); ext_evt = 8'h39;
        @(negedge clk); ext_evt = 8'h00;
        reg_read(3'd3, rd); check("R6 external event bits", rd, 16'h0039);
        reg_write(3'd4, 16'h00FF);

        // R10: set and clear in the same cycle
        @(negedge clk);
        ext_evt = 8'h01; reg_wr_en = 1'b1; reg_wr_addr = 3'd4; reg_wr_data = 16'h0021;
        @(negedge clk);
        ext_evt = 8'h00; reg_wr_en = 1'b0;
        reg_read(3'd3, rd); check("R10 set wins over clear", rd, 16'h0001);

        // R7: hardware event with mask enables irq
        reg_write(3'd2, 16'h0001);
        #0.1; check("R7 irq from masked-in event", {15'd0, irq}, 16'h0001);

        // R11: reset mid-run
        reg_write(3'd3, 16'h00FF);
        reg_write(3'd1, 16'h0123);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        reg_read(3'd3, rd); check("R11 status reset", rd, 16'h0000);
        reg_read(3'd2, rd); check("R11 mask reset", rd, 16'h0000);
        reg_read(3'd1, rd); check("R11 threshold reset", rd, 16'h0000);
        check("R11 irq reset", {15'd0, irq}, 16'h0000);

        finish_run();
    end
endmodule